// File: doc/BRIEF.md
# Group-Merging Huffman Code Table Builder

This block builds a Huffman prefix code for a stream of 5-bit symbols and then encodes a replayed stream bit-serially. A `start` pulse clears all tables and opens the scan phase. In that phase every valid symbol adds one to its 16-bit occurrence count, and each symbol begins in a group of its own whose number equals the symbol value. A `scan_done` pulse closes the scan. Merging then begins.

No tree or heap is stored. On each merge the block finds the two cheapest live groups. It prepends one code bit to every member of both groups, relabels the members into one group and adds the two frequencies. When one live group remains, `tbl_ready` rises and the block enters the output phase. In that phase it raises `req` whenever it can accept a symbol, looks the symbol up and shifts its code out most-significant bit first, one bit per clock. `err` flags a frequency that does not fit in 16 bits or a code that would exceed 31 bits.

Top module: `huff_table_builder`

## Requirements
- R1: While reset is held and after it is released, `tbl_ready`, `req`, `out_valid` and `err` are all low.
- R2: A `start` pulse clears every count and code and enters the scan phase. While scanning, each cycle with `sym_valid` high adds one to the count of `sym_in`. A `scan_done` pulse ends the scan. `sym_valid` is ignored outside the scan and output phases.
- R3: Each merge picks the live group with the lowest frequency and then the lowest-frequency live group among the rest. Equal frequencies resolve to the lower group number. Symbols with a zero count belong to no live group.
- R4: In a merge, members of the first-picked group get a 0 prepended to their code and members of the second get a 1. Every member's length grows by one. The merged group keeps the smaller of the two group numbers, and its frequency becomes the sum of the two.
- R5: `tbl_ready` rises once at most one live group remains, including when no symbol was scanned. It stays high until the next `start`.
- R6: When exactly one distinct symbol was scanned, its code is the single bit 0.
- R7: In the output phase, `req` is high exactly when no code is being shifted. A cycle with `sym_valid` and `req` high loads the code of `sym_in`. From the next cycle, `out_valid` is high for as many cycles as the code is long, with `out_bit` carrying the code MSB-first, and `req` stays low meanwhile.
- R8: Presenting a symbol whose count was zero (code length 0) emits no bits. `req` is high again in the following cycle.
- R9: `err` rises when a symbol count already at 65535 receives another occurrence (the count holds), when a merged frequency exceeds 65535, or when a code would pass 31 bits. `err` stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears tables and begins the scan phase |
| scan_done | input | 1 | Ends the scan phase and starts merging |
| sym_valid | input | 1 | Symbol present on `sym_in` |
| sym_in | input | 5 | Symbol value |
| tbl_ready | output | 1 | Code table complete |
| req | output | 1 | Ready to accept the next symbol for encoding |
| out_valid | output | 1 | `out_bit` carries a code bit |
| out_bit | output | 1 | Serial encoded data, MSB of each code first |
| err | output | 1 | Frequency overflow or code length overflow |

## Verification
The hardest condition to reach from the ports is the count overflow. It needs one symbol repeated 65536 times in a single scan. The stimulus holds `sym_valid` for a burst of 65535 cycles and confirms `err` is still low, then adds one more occurrence and confirms `err` rises. Tie-breaking is reached with equal-count symbols whose second merge pairs a merged group against a lighter leaf. This shows that the pick order follows frequency, not group number. A scoreboard holds the expected bits of each replayed symbol and compares them against `out_bit` as the design emits them.

// File: rtl/huff_pkg.sv
// Shared phase encoding for the Huffman table builder.
package huff_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SCAN  = 3'd1,
        PH_FIND  = 3'd2,
        PH_APPLY = 3'd3,
        PH_OUT   = 3'd4
    } phase_t;
endpackage

// File: rtl/huff_min_pair.sv
// Finds the two lowest-frequency live groups (ties to the lower group number)
// and registers the result when en is high.
// Assumes freq/alive are stable during the enabling cycle.
module huff_min_pair #(
    parameter int NG    = 32,
    parameter int CNT_W = 16,
    localparam int IDX_W = $clog2(NG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [NG-1:0][CNT_W-1:0]   freq,
    input  logic [NG-1:0]              alive,
    output logic [IDX_W-1:0]           g1_q,
    output logic [IDX_W-1:0]           g2_q,
    output logic                       one_q,
    output logic                       two_q
);
    logic [IDX_W-1:0] b1, b2;
    logic             f1, f2;

    // Two ordered passes: the strict compare keeps the lowest index on ties.
    always_comb begin
        b1 = '0;
        b2 = '0;
        f1 = 1'b0;
        f2 = 1'b0;
        for (int i = 0; i < NG; i++) begin
            if (alive[i] && (!f1 || freq[i] < freq[b1])) begin
                b1 = IDX_W'(i);
                f1 = 1'b1;
            end
        end
        for (int i = 0; i < NG; i++) begin
            if (alive[i] && (IDX_W'(i) != b1) && (!f2 || freq[i] < freq[b2])) begin
                b2 = IDX_W'(i);
                f2 = 1'b1;
            end
        end
    end

    // Register the selection so the merge step sees stable indices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            g1_q  <= '0;
            g2_q  <= '0;
            one_q <= 1'b0;
            two_q <= 1'b0;
        end else if (en) begin
            g1_q  <= b1;
            g2_q  <= b2;
            one_q <= f1 && !f2;
            two_q <= f2;
        end
    end
endmodule

// File: rtl/huff_bit_shifter.sv
// Shifts a right-aligned code of len bits out MSB-first, one bit per clock.
// Assumes load is only raised while idle is high.
module huff_bit_shifter #(
    parameter int CODE_W = 31,
    localparam int LEN_W = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              load,
    input  logic [CODE_W-1:0] code_in,
    input  logic [LEN_W-1:0]  len_in,
    output logic              bit_out,
    output logic              valid,
    output logic              idle
);
    logic [CODE_W-1:0] sh;
    logic [LEN_W-1:0]  cnt;

    // Load left-justified code, then shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= code_in << (CODE_W - int'(len_in));
            cnt <= len_in;
        end else if (cnt != '0) begin
            sh  <= sh << 1;
            cnt <= cnt - 1'b1;
        end
    end

    assign bit_out = sh[CODE_W-1];
    assign valid   = (cnt != '0);
    assign idle    = (cnt == '0);

    assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> idle);
    assert_stream_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !flush && len_in != '0) |=> valid);
endmodule

// File: rtl/huff_table_builder.sv
// Builds a Huffman code table by group merging and encodes symbols serially.
// Phases: scan (count), find/apply (merge loop), output (serial encode).
// Assumes start and scan_done are single-cycle pulses from the host.
module huff_table_builder #(
    parameter int SYM_W   = 5,
    parameter int CNT_W   = 16,
    parameter int LEN_MAX = 31,
    localparam int NSYM  = 1 << SYM_W,
    localparam int LEN_W = $clog2(LEN_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             scan_done,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_in,
    output logic             tbl_ready,
    output logic             req,
    output logic             out_valid,
    output logic             out_bit,
    output logic             err
);
    import huff_pkg::*;

    phase_t                        phase;
    logic [NSYM-1:0][CNT_W-1:0]    grp_freq;
    logic [NSYM-1:0]               grp_alive;
    logic [SYM_W-1:0]              sym_grp  [NSYM];
    logic [LEN_MAX-1:0]            sym_code [NSYM];
    logic [LEN_W-1:0]              sym_len  [NSYM];
    logic [SYM_W-1:0]              g1, g2, keep, drop;
    logic                          one_grp, two_grp;
    logic [CNT_W:0]                fsum;
    logic                          sh_idle, load;

    huff_min_pair #(.NG(NSYM), .CNT_W(CNT_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .en(phase == PH_FIND),
        .freq(grp_freq), .alive(grp_alive),
        .g1_q(g1), .g2_q(g2), .one_q(one_grp), .two_q(two_grp)
    );

    // Merge bookkeeping derived from the registered selection.
    always_comb begin
        keep = (g1 < g2) ? g1 : g2;
        drop = (g1 < g2) ? g2 : g1;
        fsum = {1'b0, grp_freq[g1]} + {1'b0, grp_freq[g2]};
    end

    // Phase control, counting, merging and error tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            tbl_ready <= 1'b0;
            err       <= 1'b0;
            grp_freq  <= '0;
            grp_alive <= '0;
            for (int s = 0; s < NSYM; s++) begin
                sym_grp[s]  <= SYM_W'(s);
                sym_code[s] <= '0;
                sym_len[s]  <= '0;
            end
        end else if (start) begin
            phase     <= PH_SCAN;
            tbl_ready <= 1'b0;
            err       <= 1'b0;
            grp_freq  <= '0;
            grp_alive <= '0;
            for (int s = 0; s < NSYM; s++) begin
                sym_grp[s]  <= SYM_W'(s);
                sym_code[s] <= '0;
                sym_len[s]  <= '0;
            end
        end else begin
            case (phase)
                PH_SCAN: begin
                    if (sym_valid) begin
                        grp_alive[sym_in] <= 1'b1;
                        if (&grp_freq[sym_in]) err <= 1'b1;
                        else grp_freq[sym_in] <= grp_freq[sym_in] + 1'b1;
                    end
                    if (scan_done) phase <= PH_FIND;
                end
                PH_FIND: phase <= PH_APPLY;
                PH_APPLY: begin
                    if (two_grp) begin
                        grp_alive[drop] <= 1'b0;
                        if (fsum[CNT_W]) begin
                            err            <= 1'b1;
                            grp_freq[keep] <= '1;
                        end else begin
                            grp_freq[keep] <= fsum[CNT_W-1:0];
                        end
                        for (int s = 0; s < NSYM; s++) begin
                            if (grp_freq[s] != '0 || sym_len[s] != '0) begin
                                if (sym_grp[s] == g1 || sym_grp[s] == g2) begin
                                    sym_grp[s] <= keep;
                                    if (sym_len[s] == LEN_W'(LEN_MAX)) begin
                                        err <= 1'b1;
                                    end else begin
                                        sym_len[s] <= sym_len[s] + 1'b1;
                                        if (sym_grp[s] == g2)
                                            sym_code[s][sym_len[s]] <= 1'b1;
                                    end
                                end
                            end
                        end
                        phase <= PH_FIND;
                    end else begin
                        if (one_grp && sym_len[g1] == '0) sym_len[g1] <= LEN_W'(1);
                        tbl_ready <= 1'b1;
                        phase     <= PH_OUT;
                    end
                end
                default: ;
            endcase
        end
    end

    assign load = (phase == PH_OUT) && sym_valid && sh_idle;
    assign req  = (phase == PH_OUT) && sh_idle;

    huff_bit_shifter #(.CODE_W(LEN_MAX)) u_shift (
        .clk(clk), .rst_n(rst_n), .flush(start), .load(load),
        .code_in(sym_code[sym_in]), .len_in(sym_len[sym_in]),
        .bit_out(out_bit), .valid(out_valid), .idle(sh_idle)
    );

    assert_pick_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_APPLY && two_grp) |->
        (grp_alive[g1] && grp_alive[g2] && g1 != g2 && grp_freq[g1] <= grp_freq[g2]));
    assert_req_after_table_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> tbl_ready);
    assert_ready_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_ready && !start) |=> tbl_ready);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);
    assert_no_stream_in_scan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SCAN) |-> !req);
endmodule

// File: tb/huff_table_builder_test.sv
module huff_table_builder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, scan_done = 1'b0, sym_valid = 1'b0;
    logic [4:0] sym_in = '0;
    logic tbl_ready, req, out_valid, out_bit, err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int m_cnt [32];
    int m_code[32];
    int m_len [32];
    bit exp_q[$];
    string cur_req = "R7";

    always #2 clk = ~clk;

    huff_table_builder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .scan_done(scan_done),
        .sym_valid(sym_valid), .sym_in(sym_in), .tbl_ready(tbl_ready),
        .req(req), .out_valid(out_valid), .out_bit(out_bit), .err(err)
    );

    task automatic check(input string rq, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Monitor: pops expected bits as the design emits them (R7)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected bit: actual %0d expected none", cur_req, out_bit);
            end else begin
                automatic bit e = exp_q.pop_front();
                if (out_bit != e) begin
                    errors++;
                    $display("FAIL %s out_bit: actual %0d expected %0d", cur_req, out_bit, e);
                end
            end
            check("R7", req, 0, "req during shifting");
        end
    end

    // Reference code model built from R3, R4 and R6
    task automatic build_model();
        int mg[32]; int mf[32]; bit ma[32];
        int na, a, b, keep, other;
        for (int s = 0; s < 32; s++) begin
            mg[s] = s; mf[s] = m_cnt[s]; ma[s] = (m_cnt[s] != 0);
            m_code[s] = 0; m_len[s] = 0;
        end
        forever begin
            na = 0;
            for (int s = 0; s < 32; s++) if (ma[s]) na++;
            if (na < 2) break;
            a = -1; b = -1;
            for (int s = 0; s < 32; s++) if (ma[s] && (a < 0 || mf[s] < mf[a])) a = s;
            for (int s = 0; s < 32; s++) if (ma[s] && s != a && (b < 0 || mf[s] < mf[b])) b = s;
            keep = (a < b) ? a : b;
            other = (a < b) ? b : a;
            for (int s = 0; s < 32; s++) begin
                if (m_cnt[s] != 0 && (mg[s] == a || mg[s] == b)) begin
                    if (mg[s] == b) m_code[s] = m_code[s] | (1 << m_len[s]);
                    m_len[s]++;
                    mg[s] = keep;
                end
            end
            mf[keep] = mf[a] + mf[b];
            ma[other] = 0;
        end
        for (int s = 0; s < 32; s++) if (m_cnt[s] != 0 && m_len[s] == 0) m_len[s] = 1;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s < 32; s++) m_cnt[s] = 0;
    endtask

    task automatic scan_sym(input int s);
        sym_in = 5'(s); sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        m_cnt[s]++;
    endtask

    task automatic finish_scan();
        int guard = 0;
        scan_done = 1'b1;
        @(negedge clk);
        scan_done = 1'b0;
        while (!tbl_ready && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        check("R5", tbl_ready, 1, "tbl_ready after merging");
        build_model();
    endtask

    // Driver: pushes expected bits, then presents the symbol
    task automatic send_out(input int s);
        int guard = 0;
        while (!req && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        for (int i = m_len[s] - 1; i >= 0; i--) exp_q.push_back(bit'((m_code[s] >> i) & 1));
        sym_in = 5'(s); sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic drain(input string rq);
        int guard = 0;
        while ((exp_q.size() != 0 || !req) && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(rq, exp_q.size(), 0, "expected bits left over");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", tbl_ready, 0, "tbl_ready in reset");
        check("R1", req, 0, "req in reset");
        check("R1", out_valid, 0, "out_valid in reset");
        check("R1", err, 0, "err in reset");
        rst_n = 1'b1;
        // Symbols before any start are ignored: tables stay empty (R2)
        scan_sym(9);
        @(negedge clk);
        check("R1", tbl_ready, 0, "tbl_ready after reset");
        check("R2", req, 0, "req idle phase");

        // Case 1: counts 3->1, 7->2, 10->4 (R2, R4): codes 00, 01, 1
        do_start();
        scan_sym(10); scan_sym(7); scan_sym(10); scan_sym(3);
        scan_sym(10); scan_sym(7); scan_sym(10);
        finish_scan();
        check("R4", m_len[3], 2, "model len sym3");
        check("R4", m_code[10], 1, "model code sym10");
        check("R7", req, 1, "req in output phase");
        cur_req = "R4";
        send_out(3); send_out(7); send_out(10); send_out(10); send_out(3);
        drain("R4");

        // Case 2: ties, 2,5,9 each once (R3): 9="0", 2="10", 5="11"
        do_start();
        check("R5", tbl_ready, 0, "tbl_ready cleared by start");
        scan_sym(5); scan_sym(2); scan_sym(9);
        finish_scan();
        check("R3", m_code[9] * 4 + m_len[9], 1, "model sym9 code/len");
        cur_req = "R3";
        send_out(2); send_out(5); send_out(9);
        drain("R3");

        // Zero-count symbol emits nothing (R8)
        send_out(17);
        check("R8", out_valid, 0, "no bits for unused symbol");
        check("R8", req, 1, "req back next cycle");

        // Case 3: wider alphabet mix (R3, R4)
        do_start();
        for (int k = 0; k < 12; k++) scan_sym((k * 7) % 11);
        scan_sym(30); scan_sym(30); scan_sym(31);
        finish_scan();
        cur_req = "R4";
        for (int s = 0; s < 11; s++) send_out(s);
        send_out(30); send_out(31);
        drain("R4");

        // Case 4: single distinct symbol -> code "0" (R6)
        do_start();
        scan_sym(4); scan_sym(4); scan_sym(4);
        finish_scan();
        cur_req = "R6";
        send_out(4);
        check("R6", out_valid, 1, "one bit emitted");
        check("R6", out_bit, 0, "bit is zero");
        drain("R6");

        // Case 5: empty scan still completes (R5)
        do_start();
        finish_scan();
        check("R5", req, 1, "req after empty scan");

        // Case 6: count overflow (R9)
        do_start();
        sym_in = 5'd1; sym_valid = 1'b1;
        repeat (65535) @(negedge clk);
        sym_valid = 1'b0;
        check("R9", err, 0, "err at count 65535");
        scan_sym(1);
        check("R9", err, 1, "err on count overflow");
        @(negedge clk);
        check("R9", err, 1, "err sticky");
        do_start();
        check("R9", err, 0, "err cleared by start");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule